// File: doc/BRIEF.md
# Programmable Interval Timer Unit

This block holds two timers that advance on a shared, prescaled timer tick. The first is a 12-bit interval timer. It counts down from a programmed reload value. When it is at zero and a further tick arrives, it reloads and emits a one-clock interrupt pulse. Software uses it as a periodic interrupt source. The second is a 16-bit free-running up counter. Software can preset it with a two-byte write sequence and reads it back to timestamp events.

The timer tick comes from one of several slow timer-clock sources, selected by `src_sel_i`. Each source passes through a two-flop synchronizer into the block clock domain. Rising edges of the selected source are then divided by a programmable prescaler. A byte-wide register bus with a 2-bit address reaches both timers. Address 0 carries the interval low byte, address 1 the interval high byte, address 2 the counter low byte and address 3 the counter high byte. Writes to addresses 0 and 1 set the reload value. Reads from them return the live interval count.

The free-running preload is sequenced by a small state machine with two states. FRC_IDLE is the resting state. FRC_ARMED means a low byte is held. The transitions are:
- arm: FRC_IDLE to FRC_ARMED on a low-byte write.
- rearm: FRC_ARMED to FRC_ARMED on another low-byte write, which replaces the held byte.
- commit: FRC_ARMED to FRC_IDLE on a high-byte write, which loads the counter.
- A high-byte write in FRC_IDLE changes nothing.

Top module: `tmr_unit`

## Requirements
- R1: After reset the interval count, the free-running count, the held preload byte and the prescaler are zero, the preload machine is in FRC_IDLE, `irq_o` is low, and all four read addresses return 0x00.
- R2: Only rising edges of the source picked by `src_sel_i` advance the timers. Each source passes a two-flop synchronizer first. Edges on unselected sources have no effect.
- R3: The prescaler emits one timer tick for every `div_i`+1 rising edges of the selected source. Without a tick neither timer changes.
- R4: On each tick the interval timer decrements. On a tick while it is at zero, it loads the reload value instead and raises an interrupt. Its period is therefore reload+1 ticks, and a reload value of zero gives an interrupt on every tick.
- R5: `irq_o` is high for exactly one clock per reload event, in the clock after the reloading tick.
- R6: A write to address 0 sets reload bits [7:0]. A write to address 1 sets reload bits [11:8] from `wdata_i[3:0]`. A changed reload value does not disturb the running count and is used at the next reload.
- R7: A read of address 0 returns interval count bits [7:0]. A read of address 1 returns the count's bits [11:8] in bits [3:0], with bits [7:4] zero.
- R8: The free-running counter increments by one on every tick and wraps from 0xFFFF to 0x0000. Reads of address 2 and address 3 return its low and high bytes.
- R9: A write to address 2 only holds a low byte and leaves the counter unchanged. A following write to address 3 loads the counter with {high byte, held low byte}. A later low write replaces the held byte.
- R10: A write to address 3 with no low byte held (state FRC_IDLE) leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_clk_i | input | 4 | Raw timer-clock sources |
| src_sel_i | input | 2 | Index of the source that drives the prescaler |
| div_i | input | 8 | Prescaler divide value minus one |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 interval low, 1 interval high, 2 counter low, 3 counter high) |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| irq_o | output | 1 | One-clock interrupt pulse per interval reload |

## Verification
The bench walks a table of reload, prescale and edge-count settings and compares interrupt counts and residual counts against closed-form values. This catches a timer that reloads one tick early or late, or a zero reload that stalls instead of firing on every tick. Directed tests go after the preload sequence. A design that loaded on the low byte, accepted a bare high byte, or kept the first of two low bytes would show a wrong counter value. Further tests cover the 0xFFFF wrap, a reload change in mid-count that must not take effect until the next reload, a prescaler that slips by one edge, and edges on unselected sources that must stay invisible.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam logic [1:0] ADDR_IVAL_LO = 2'd0;
    localparam logic [1:0] ADDR_IVAL_HI = 2'd1;
    localparam logic [1:0] ADDR_FRC_LO  = 2'd2;
    localparam logic [1:0] ADDR_FRC_HI  = 2'd3;

    typedef enum logic {
        FRC_IDLE  = 1'b0,
        FRC_ARMED = 1'b1
    } frc_state_t;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int NSRC  = 4,
    parameter int SEL_W = 2,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [PRE_W-1:0] div_i,
    output logic             tick_o
);
    logic [NSRC-1:0]  sync1_q, sync2_q;
    logic             prev_q;
    logic             sel_src;
    logic             rise;
    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= src_i;
            sync2_q <= sync1_q;
            prev_q  <= sel_src;
        end
    end

    always_comb begin
        sel_src = sync2_q[sel_i];
        rise    = sel_src & ~prev_q;
        tick_o  = rise && (pre_q >= div_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (rise) begin
            if (pre_q >= div_i) pre_q <= '0;
            else                pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_interval.sv
module tmr_interval #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] cnt_o,
    output logic         irq_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
            irq_o <= 1'b0;
        end else begin
            irq_o <= 1'b0;
            if (tick_i) begin
                if (cnt_o == '0) begin
                    cnt_o <= reload_i;
                    irq_o <= 1'b1;
                end else begin
                    cnt_o <= cnt_o - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tmr_freerun.sv
module tmr_freerun
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         lo_wr_i,
    input  logic         hi_wr_i,
    input  logic [7:0]   wdata_i,
    output logic [W-1:0] cnt_o,
    output logic         armed_o
);
    frc_state_t state_q, state_d;
    logic [7:0] held_q;
    logic       load;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FRC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FRC_IDLE:  if (lo_wr_i) state_d = FRC_ARMED;
            FRC_ARMED: if (hi_wr_i) state_d = FRC_IDLE;
            default:   state_d = FRC_IDLE;
        endcase
    end

    always_comb begin
        load    = (state_q == FRC_ARMED) && hi_wr_i;
        armed_o = (state_q == FRC_ARMED);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
            cnt_o  <= '0;
        end else begin
            if (lo_wr_i) held_q <= wdata_i;
            if (load)        cnt_o <= {wdata_i[W-9:0], held_q};
            else if (tick_i) cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int PRE_W  = 8,
    parameter int IVAL_W = 12,
    parameter int FRC_W  = 16,
    localparam int SEL_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_clk_i,
    input  logic [SEL_W-1:0] src_sel_i,
    input  logic [PRE_W-1:0] div_i,
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       rdata_o,
    output logic             irq_o
);
    logic              tick;
    logic [IVAL_W-1:0] reload_q;
    logic [IVAL_W-1:0] ival_cnt;
    logic [FRC_W-1:0]  frc_cnt;
    logic              frc_armed;
    logic              frc_lo_wr, frc_hi_wr;

    tmr_tick_gen #(.NSRC(NSRC), .SEL_W(SEL_W), .PRE_W(PRE_W)) i_tick (
        .clk(clk), .rst_n(rst_n), .src_i(src_clk_i), .sel_i(src_sel_i),
        .div_i(div_i), .tick_o(tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (wr_i) begin
            if (addr_i == ADDR_IVAL_LO) reload_q[7:0] <= wdata_i;
            if (addr_i == ADDR_IVAL_HI) reload_q[IVAL_W-1:8] <= wdata_i[IVAL_W-9:0];
        end
    end

    tmr_interval #(.W(IVAL_W)) i_ival (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .reload_i(reload_q),
        .cnt_o(ival_cnt), .irq_o(irq_o)
    );

    always_comb begin
        frc_lo_wr = wr_i && (addr_i == ADDR_FRC_LO);
        frc_hi_wr = wr_i && (addr_i == ADDR_FRC_HI);
    end

    tmr_freerun #(.W(FRC_W)) i_frc (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .lo_wr_i(frc_lo_wr),
        .hi_wr_i(frc_hi_wr), .wdata_i(wdata_i), .cnt_o(frc_cnt),
        .armed_o(frc_armed)
    );

    always_comb begin
        unique case (addr_i)
            ADDR_IVAL_LO: rdata_o = ival_cnt[7:0];
            ADDR_IVAL_HI: rdata_o = 8'(ival_cnt[IVAL_W-1:8]);
            ADDR_FRC_LO:  rdata_o = frc_cnt[7:0];
            default:      rdata_o = 8'(frc_cnt[FRC_W-1:8]);
        endcase
    end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
    parameter int IVAL_W = 12,
    parameter int FRC_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              irq_o,
    input logic [IVAL_W-1:0] ival_cnt,
    input logic [IVAL_W-1:0] reload_q,
    input logic [FRC_W-1:0]  frc_cnt,
    input logic              frc_armed,
    input logic              frc_lo_wr,
    input logic              frc_hi_wr,
    input logic [1:0]        addr_i,
    input logic [7:0]        rdata_o
);
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R5
    AST_IRQ_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tick && ival_cnt == '0 |=> irq_o); // R4
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        tick && ival_cnt == '0 |=> ival_cnt == $past(reload_q)); // R6
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ival_cnt) && !irq_o); // R3
    AST_FRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !frc_hi_wr |=> frc_cnt == FRC_W'($past(frc_cnt) + 1'b1)); // R8
    AST_LOW_ONLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        frc_lo_wr && !tick |=> $stable(frc_cnt)); // R9
    AST_BARE_HIGH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        frc_hi_wr && !frc_armed && !tick |=> $stable(frc_cnt)); // R10
    AST_HIGH_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        addr_i == 2'd1 |-> rdata_o[7:4] == 4'h0); // R7
endmodule

bind tmr_unit tmr_unit_chk #(.IVAL_W(IVAL_W), .FRC_W(FRC_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .irq_o(irq_o),
    .ival_cnt(ival_cnt), .reload_q(reload_q), .frc_cnt(frc_cnt),
    .frc_armed(frc_armed), .frc_lo_wr(frc_lo_wr), .frc_hi_wr(frc_hi_wr),
    .addr_i(addr_i), .rdata_o(rdata_o)
);

// File: tb/test_tmr_unit.sv
module test_tmr_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_clk = '0;
    logic [1:0] src_sel = '0;
    logic [7:0] div = '0;
    logic       wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;
    int irq_total = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_unit i_tmr_unit (
        .clk(clk), .rst_n(rst_n), .src_clk_i(src_clk), .src_sel_i(src_sel),
        .div_i(div), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    always @(posedge clk) if (rst_n && irq) irq_total <= irq_total + 1;

    typedef struct packed {
        logic [11:0] rld;
        logic [7:0]  dv;
        logic [7:0]  pulses;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{rld: 12'd5,     dv: 8'd0, pulses: 8'd20},
        '{rld: 12'd0,     dv: 8'd0, pulses: 8'd7},
        '{rld: 12'd0,     dv: 8'd3, pulses: 8'd10},
        '{rld: 12'd2,     dv: 8'd1, pulses: 8'd13},
        '{rld: 12'h1A5,   dv: 8'd0, pulses: 8'd1},
        '{rld: 12'd3,     dv: 8'd2, pulses: 8'd2}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        src_clk = '0;
        wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        src_clk[idx] = 1'b1;
        repeat (4) @(negedge clk);
        src_clk[idx] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic int rd_frc_exp(input int t);
        return t & 16'hFFFF;
    endfunction

    task automatic read16(input logic [1:0] lo_a, output int v);
        logic [7:0] lo, hi;
        bus_rd(lo_a, lo);
        bus_rd(lo_a + 2'd1, hi);
        v = {hi, lo};
    endtask

    initial begin
        logic [7:0] b;
        int v;
        int base;
        do_reset();
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            bus_rd(a[1:0], b);
            check("R1 reset read", b, 0);
        end
        check("R1 irq low", irq, 0);

        // table walk: R3 R4 R5 R6 R7 R8
        foreach (VECS[i]) begin
            int t, r, e_irq, e_cnt;
            do_reset();
            src_sel = 2'd0;
            div = VECS[i].dv;
            bus_wr(2'd0, VECS[i].rld[7:0]);
            bus_wr(2'd1, {4'h0, VECS[i].rld[11:8]});
            base = irq_total;
            for (int p = 0; p < VECS[i].pulses; p++) pulse(0);
            t = VECS[i].pulses / (VECS[i].dv + 1);
            r = VECS[i].rld;
            e_irq = (t == 0) ? 0 : (t - 1) / (r + 1) + 1;
            e_cnt = (t == 0) ? 0 : r - ((t - 1) % (r + 1));
            check("R4/R5 irq count", irq_total - base, e_irq);
            bus_rd(2'd0, b);
            check("R7 count low", b, e_cnt & 8'hFF);
            bus_rd(2'd1, b);
            check("R7 count high", b, e_cnt >> 8);
            read16(2'd2, v);
            check("R8 frc after ticks", v, rd_frc_exp(t));
        end

        // R3 prescaler boundary
        do_reset();
        div = 8'd3;
        repeat (3) pulse(0);
        read16(2'd2, v);
        check("R3 no tick before div+1 edges", v, 0);
        pulse(0);
        read16(2'd2, v);
        check("R3 tick on edge div+1", v, 1);

        // R2 source select
        do_reset();
        div = 8'd0;
        src_sel = 2'd2;
        pulse(0);
        pulse(3);
        read16(2'd2, v);
        check("R2 unselected sources ignored", v, 0);
        pulse(2);
        read16(2'd2, v);
        check("R2 selected source counts", v, 1);
        src_sel = 2'd0;

        // R9 preload sequence
        bus_wr(2'd2, 8'h34);
        read16(2'd2, v);
        check("R9 low write alone no load", v, 1);
        bus_wr(2'd3, 8'h12);
        read16(2'd2, v);
        check("R9 load after high write", v, 16'h1234);
        pulse(0);
        read16(2'd2, v);
        check("R8 count from loaded value", v, 16'h1235);

        // R10 bare high write
        bus_wr(2'd3, 8'h77);
        read16(2'd2, v);
        check("R10 high write without low ignored", v, 16'h1235);

        // R9 second low replaces held, R8 wrap
        bus_wr(2'd2, 8'h11);
        bus_wr(2'd2, 8'hFF);
        bus_wr(2'd3, 8'hFF);
        read16(2'd2, v);
        check("R9 latest low byte used", v, 16'hFFFF);
        pulse(0);
        read16(2'd2, v);
        check("R8 wrap to zero", v, 0);

        // R6 reload change takes effect at next reload only
        do_reset();
        bus_wr(2'd0, 8'd2);
        pulse(0);
        read16(2'd0, v);
        check("R6 first reload", v, 2);
        bus_wr(2'd0, 8'd7);
        read16(2'd0, v);
        check("R6 running count undisturbed", v, 2);
        base = irq_total;
        repeat (3) pulse(0);
        read16(2'd0, v);
        check("R6 new reload applied", v, 7);
        check("R5 one irq at new reload", irq_total - base, 1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule